// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits each and returns the exact `2N`-bit signed product. The multiplier operand is recoded into `N/2` radix-4 digits. Each digit takes one of the values -2, -1, 0, +1 or +2. Each digit picks one partial-product row from the multiplicand, and that row is weighted by a power of four. Negative rows are formed as the bitwise inverse of the selected multiple. The missing +1 for each negative row is placed in a separate sign row at the row's lowest column. A short constant-and-inverted-sign prefix on each row stands in for full sign extension.

All rows, including the sign row, are summed by a carry-save chain of 3:2 compressors. One carry-propagate addition then produces the product. Parameter `OUT_REG` selects the output mode. With `OUT_REG = 0` the product is purely combinational. With `OUT_REG = 1` a single output register follows the adder, and that register is cleared by a synchronous active-high reset.

Top module: `booth_r4_mult`

## Requirements
- R1: For every pair of signed operands, `product` equals the exact signed product `mcand * mplier`, expressed in 2N bits.
- R2: The multiplier is recoded with a 0 appended below its LSB. Overlapping 3-bit groups are taken every two bits, and group values 000..111 map to digits 0,+1,+1,+2,-2,-1,-1,-0. For example, 25 × -35 gives -875.
- R3: The most negative operand times itself gives 2^(2N-2), with bit 2N-2 set and all other bits clear. The result does not wrap.
- R4: When either operand is zero, the product is zero.
- R5: When both operands are non-zero, product bit 2N-1 equals the XOR of the two operand sign bits.
- R6: A multiplier of +1 returns the sign-extended multiplicand. A multiplier of -1 returns its negation.
- R7: With `OUT_REG = 1` the product of operands present at a rising clock edge appears after that edge and not before. With `OUT_REG = 0` it follows the operands without a clock.
- R8: With `OUT_REG = 1`, an asserted `rst` at a rising edge forces `product` to zero, whatever the operands are. The output mode with `OUT_REG = 0` ignores `rst`.
- R9: Digits of magnitude two are handled exactly. A multiplier of 2 gives 2·mcand, and a multiplier of -2 gives -2·mcand, which exercises the -2 and -0 digits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier, the operand that is Booth-recoded |
| product | output | 2N | Signed product |

## Verification
In the registered mode, a reset and a fresh operand pair can arrive at the same clock edge. The bench provokes this by raising `rst` in the same cycle that it drives new operands. The registered product must read zero after that edge, while the combinational instance already shows the true product. Once reset is released, the next edge must load that same operand pair's product. The collision also covers the opposite case: the product must not appear before the edge (R7).

// File: rtl/booth_pkg.sv
package booth_pkg;

    // One radix-4 digit: sign, magnitude one, magnitude two.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_digit_t;

    // Recode one overlapping group {upper, middle, lower} into a digit.
    function automatic booth_digit_t recode_group(input logic [2:0] grp);
        booth_digit_t d;
        d = '0;
        unique case (grp)
            3'b000: d = '{neg: 1'b0, one: 1'b0, two: 1'b0};
            3'b001,
            3'b010: d = '{neg: 1'b0, one: 1'b1, two: 1'b0};
            3'b011: d = '{neg: 1'b0, one: 1'b0, two: 1'b1};
            3'b100: d = '{neg: 1'b1, one: 1'b0, two: 1'b1};
            3'b101,
            3'b110: d = '{neg: 1'b1, one: 1'b1, two: 1'b0};
            default: d = '{neg: 1'b1, one: 1'b0, two: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]                mplier,
    output booth_digit_t [N/2-1:0]      digits
);
    localparam int NDIG = N / 2;

    // Multiplier with the implicit zero below its LSB.
    logic [N:0] ext;
    assign ext = {mplier, 1'b0};

    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        assign digits[k] = recode_group(ext[2*k +: 3]);
    end

endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
    import booth_pkg::*;
#(
    parameter int N   = 16,
    parameter int ROW = 0
) (
    input  logic [N-1:0]   mcand,
    input  booth_digit_t   dig,
    output logic [2*N-1:0] row,
    output logic           sgn
);
    localparam int W  = 2 * N;
    localparam int SH = 2 * ROW;

    logic [N:0] mag;
    logic [N:0] pp;
    logic       e;

    // Select 0, M or 2M in N+1 bits.
    always_comb begin
        if (dig.two)      mag = {mcand, 1'b0};
        else if (dig.one) mag = {mcand[N-1], mcand};
        else              mag = '0;
    end

    // Ones' complement for negative digits; the +1 goes to the sign row.
    assign pp  = dig.neg ? ~mag : mag;
    assign e   = pp[N];
    assign sgn = dig.neg;

    if (ROW == 0) begin : g_first
        // First row: sign, sign, inverted sign above the body.
        always_comb begin
            row          = '0;
            row[N-1:0]   = pp[N-1:0];
            row[N]       = e;
            row[N+1]     = e;
            row[N+2]     = ~e;
        end
    end else begin : g_later
        // Later rows: inverted sign, then a constant one above it.
        always_comb begin
            row               = '0;
            row[SH +: N]      = pp[N-1:0];
            row[SH + N]       = ~e;
            if (SH + N + 1 < W) row[SH + N + 1] = 1'b1;
        end
    end

endmodule

// File: rtl/booth_csa3.sv
module booth_csa3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] maj;

    assign s   = x ^ y ^ z;
    assign maj = (x & y) | (x & z) | (y & z);
    assign c   = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/booth_csa_tree.sv
module booth_csa_tree #(
    parameter int W    = 32,
    parameter int ROWS = 9
) (
    input  logic [ROWS-1:0][W-1:0] rows,
    output logic [W-1:0]           sum_vec,
    output logic [W-1:0]           car_vec
);
    localparam int STAGES = ROWS - 2;

    logic [STAGES:0][W-1:0] ss;
    logic [STAGES:0][W-1:0] cc;

    assign ss[0] = rows[0];
    assign cc[0] = rows[1];

    // Each stage folds one more row into the redundant pair.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        booth_csa3 #(.W(W)) u_csa (
            .x (ss[k]),
            .y (cc[k]),
            .z (rows[k+2]),
            .s (ss[k+1]),
            .c (cc[k+1])
        );
    end

    assign sum_vec = ss[STAGES];
    assign car_vec = cc[STAGES];

endmodule

// File: rtl/booth_r4_mult.sv
module booth_r4_mult
    import booth_pkg::*;
#(
    parameter int N       = 16,
    parameter int OUT_REG = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product
);
    localparam int NDIG = N / 2;
    localparam int W    = 2 * N;
    localparam int ROWS = NDIG + 1;
    localparam logic [N-1:0] MINV   = {1'b1, {(N-1){1'b0}}};
    localparam logic [W-1:0] MINSQ  = {2'b01, {(W-2){1'b0}}};

    booth_digit_t [NDIG-1:0] digits;
    logic [ROWS-1:0][W-1:0]  rows;
    logic [NDIG-1:0]         sgn;
    logic [W-1:0]            sign_row;
    logic [W-1:0]            sum_vec;
    logic [W-1:0]            car_vec;
    logic [W-1:0]            prod_c;

    booth_recoder #(.N(N)) u_recoder (
        .mplier (mplier),
        .digits (digits)
    );

    for (genvar k = 0; k < NDIG; k++) begin : g_rows
        booth_row_gen #(.N(N), .ROW(k)) u_row (
            .mcand (mcand),
            .dig   (digits[k]),
            .row   (rows[k]),
            .sgn   (sgn[k])
        );
    end

    // Completion bits of negative rows, each at its row's lowest column.
    always_comb begin
        sign_row = '0;
        for (int k = 0; k < NDIG; k++) sign_row[2*k] = sgn[k];
    end
    assign rows[NDIG] = sign_row;

    booth_csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
        .rows    (rows),
        .sum_vec (sum_vec),
        .car_vec (car_vec)
    );

    assign prod_c = sum_vec + car_vec;

    if (OUT_REG != 0) begin : g_reg
        logic [W-1:0] prod_q;
        always_ff @(posedge clk) begin
            if (rst) prod_q <= '0;
            else     prod_q <= prod_c;
        end
        assign product = prod_q;

        p_zero_operand_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && ($past(mcand) == '0 || $past(mplier) == '0)) |-> product == '0);
        p_sign_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mcand) != '0 && $past(mplier) != '0)
                |-> product[W-1] == ($past(mcand[N-1]) ^ $past(mplier[N-1])));
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mcand) == MINV && $past(mplier) == MINV) |-> product == MINSQ);
        p_unit_mult_r6: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mplier) == N'(1))
                |-> product == {{N{$past(mcand[N-1])}}, $past(mcand)});
        p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> product == '0);
    end else begin : g_comb
        assign product = prod_c;

        p_zero_operand_r4: assert property (@(posedge clk) disable iff (rst)
            (mcand == '0 || mplier == '0) |-> product == '0);
        p_sign_r5: assert property (@(posedge clk) disable iff (rst)
            (mcand != '0 && mplier != '0) |-> product[W-1] == (mcand[N-1] ^ mplier[N-1]));
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            (mcand == MINV && mplier == MINV) |-> product == MINSQ);
        p_unit_mult_r6: assert property (@(posedge clk) disable iff (rst)
            (mplier == N'(1)) |-> product == {{N{mcand[N-1]}}, mcand});
    end

endmodule

// File: tb/booth_r4_mult_bench.sv
module booth_r4_mult_bench;
    localparam int N = 16;
    localparam int W = 2 * N;
    localparam int NV = 12;

    // Stimulus and hand-worked expected products.
    localparam int VA [NV] = '{25, -32768, 0, 7, -5, 13, -13, 32767, -32768, 1000, -1, 21845};
    localparam int VB [NV] = '{-35, -32768, 1234, 1, 13, -5, -5, 32767, 32767, -2, -1, 3};
    localparam int VP [NV] = '{-875, 1073741824, 0, 7, -65, -65, 65, 1073676289,
                               -1073709056, -2000, 1, 65535};
    localparam string VT [NV] = '{"R2", "R3", "R4", "R6", "R1", "R1", "R5", "R1",
                                  "R1", "R9", "R6", "R1"};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] mcand = '0;
    logic [N-1:0] mplier = '0;
    logic [W-1:0] prod_reg;
    logic [W-1:0] prod_cmb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    booth_r4_mult #(.N(N), .OUT_REG(1)) u_booth_r4_mult (
        .clk(clk), .rst(rst), .mcand(mcand), .mplier(mplier), .product(prod_reg));

    booth_r4_mult #(.N(N), .OUT_REG(0)) u_booth_r4_mult_comb (
        .clk(clk), .rst(rst), .mcand(mcand), .mplier(mplier), .product(prod_cmb));

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [W-1:0] r;
        r = $signed(a) * $signed(b);
        return r;
    endfunction

    // Drive at a falling edge, check both outputs at the next falling edge.
    task automatic apply(input string tag, input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [W-1:0] exp);
        @(negedge clk);
        mcand  = a;
        mplier = b;
        @(negedge clk);
        check({tag, " registered"}, prod_reg, exp);
        check({tag, " combinational"}, prod_cmb, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] prev;
        repeat (2) @(negedge clk);
        check("R8 reset state", prod_reg, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            apply(VT[i], N'(VA[i]), N'(VB[i]), W'(VP[i]));

        // R9: digit of magnitude two, both signs.
        apply("R9 times two", 16'sd1234, 16'sd2, ref_mul(16'sd1234, 16'sd2));
        apply("R9 times minus two", -16'sd777, -16'sd2, ref_mul(-16'sd777, -16'sd2));
        // R6: minus one negates, including the most negative multiplicand.
        apply("R6 minus one", 16'h8000, 16'hFFFF, 32'h0000_8000);
        // R2: alternating recode patterns.
        apply("R2 pattern", 16'h7FFF, 16'h5555, ref_mul(16'h7FFF, 16'h5555));
        apply("R2 pattern", 16'h8001, 16'hAAAA, ref_mul(16'h8001, 16'hAAAA));

        // R7: registered output holds until the edge, combinational follows at once.
        @(negedge clk);
        prev   = prod_reg;
        mcand  = 16'sd300;
        mplier = -16'sd41;
        #1;
        check("R7 no early update", prod_reg, prev);
        check("R7 combinational", prod_cmb, 32'hFFFF_CFF4);
        @(negedge clk);
        check("R7 one-cycle latency", prod_reg, 32'hFFFF_CFF4);

        // R8: reset collides with new operands.
        @(negedge clk);
        rst    = 1'b1;
        mcand  = 16'sd99;
        mplier = 16'sd101;
        @(negedge clk);
        check("R8 reset wins", prod_reg, '0);
        check("R8 comb ignores reset", prod_cmb, 32'd9999);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after release", prod_reg, 32'd9999);

        // R1: random operands against a signed reference.
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] ra;
            logic [N-1:0] rb;
            ra = N'($urandom);
            rb = N'($urandom);
            apply("R1 random", ra, rb, ref_mul(ra, rb));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule